// File: doc/BRIEF.md
# Closed-Loop DC Offset Remover

This block strips a slowly varying DC offset from a stream of signed fixed-point samples. Every accepted sample has the current offset estimate taken away from it, and the result is the corrected output. The estimate is an integrator fed by the corrected output, scaled by a loop gain. The feedback passes through a single sample of delay, so the estimate used for a sample depends only on earlier outputs.

The result is a first-order high-pass response, (1 − z⁻¹)/(1 − (1−β)z⁻¹). It has a zero at DC and a pole at 1 − β. A constant input decays towards zero at the output, at a rate that the loop gain sets.

The loop gain β is 2⁻ᵏ, and the gain select chooses k. The integrator holds FRAC fractional bits below the sample LSB (FRAC = KMAX), so the scaled update is exact for every legal k. A synchronous clear empties the integrator. The integrator value is visible on a read-only output.

The design is a datapath with no control states. It holds two registered elements: the integrator, and the output register with its valid flag.

Top module: `dcoc_loop`

## Requirements
- R1: When in_valid is high, the next clock edge loads out_data with sat(in_data − floor(acc / 2^FRAC)). Here acc is the integrator value before that edge, or zero when clr is high in the same cycle. out_valid is in_valid delayed by one register, and acc_out shows the integrator register.
- R2: On an edge where in_valid is high, the integrator becomes acc + y·2^(FRAC−k), where y is the corrected sample of that edge and acc is replaced by zero when clr is also high. On an edge where both in_valid and clr are low, the integrator keeps its value.
- R3: The corrected sample saturates to [−2^(DW−1), 2^(DW−1)−1] and does not wrap. A non-negative input with a negative estimate never gives a negative output. The integrator sum saturates to the signed AW-bit range.
- R4: When clr is high with in_valid low, acc_out is zero after the edge. When clr and in_valid are high together, the output for that sample equals in_data unchanged.
- R5: k_sel is clamped to [KMIN, KMAX], so a value of 0 acts as 4 and a value of 15 acts as 12 with the default parameters. A new k_sel applies from the next valid sample, and the integrator is not cleared.
- R6: With a constant offset plus a zero-mean periodic signal at the input, the mean output over whole periods is below one LSB in magnitude once 12/β samples have passed.
- R7: After reset, out_valid is 0, out_data is 0 and acc_out is 0.
- R8: out_data keeps its value on cycles that follow an edge where in_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous integrator clear |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DW | Signed input sample |
| k_sel | input | SEL_W | Loop gain exponent, β = 2^−k |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | DW | Signed corrected sample |
| acc_out | output | AW | Integrator value, FRAC fractional bits |

## Verification
Inputs are applied on one clock edge, and both the corrected sample and the updated integrator appear on the next. The bench therefore drives on a falling edge and compares outputs on the following falling edge. Every sample pushes its predicted output and integrator value into a queue, and the queue is popped only when out_valid is high. A clear without a sample is checked on the falling edge after it. The hold check on out_data runs on each falling edge where out_valid is low, and the DC mean check sums only the outputs tagged inside its window.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
    localparam int DCOC_DW_DEF   = 16;
    localparam int DCOC_KMIN_DEF = 4;
    localparam int DCOC_KMAX_DEF = 12;

    typedef enum logic [1:0] {
        SAT_NONE = 2'b00,
        SAT_HIGH = 2'b01,
        SAT_LOW  = 2'b10
    } sat_kind_e;

    function automatic int clamp_exp(input int k, input int kmin, input int kmax);
        if (k < kmin) return kmin;
        if (k > kmax) return kmax;
        return k;
    endfunction
endpackage

// File: rtl/dcoc_gain_sel.sv
module dcoc_gain_sel
    import dcoc_pkg::*;
#(
    parameter int KMIN  = DCOC_KMIN_DEF,
    parameter int KMAX  = DCOC_KMAX_DEF,
    parameter int SEL_W = $clog2(KMAX + 1),
    parameter int SH_W  = $clog2(KMAX - KMIN + 1) + 1
) (
    input  logic [SEL_W-1:0] k_sel,
    output logic [SH_W-1:0]  lshift
);
    int k_eff;

    always_comb begin
        k_eff  = clamp_exp(int'(k_sel), KMIN, KMAX);
        lshift = SH_W'(KMAX - k_eff);
    end
endmodule

// File: rtl/dcoc_correct.sv
module dcoc_correct
    import dcoc_pkg::*;
#(
    parameter int DW   = DCOC_DW_DEF,
    parameter int FRAC = DCOC_KMAX_DEF,
    parameter int AW   = DW + FRAC
) (
    input  logic signed [AW-1:0] acc,
    input  logic                 zero_est,
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y,
    output sat_kind_e            sat
);
    localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [AW-1:0] est_full;
    logic signed [DW-1:0] est;
    logic signed [DW:0]   diff;

    always_comb begin
        est_full = zero_est ? '0 : (acc >>> FRAC);
        est      = est_full[DW-1:0];
        diff     = {x[DW-1], x} - {est[DW-1], est};
        if (diff[DW] != diff[DW-1]) begin
            sat = diff[DW] ? SAT_LOW : SAT_HIGH;
            y   = diff[DW] ? YMIN : YMAX;
        end else begin
            sat = SAT_NONE;
            y   = diff[DW-1:0];
        end
    end
endmodule

// File: rtl/dcoc_accum.sv
module dcoc_accum
    import dcoc_pkg::*;
#(
    parameter int DW   = DCOC_DW_DEF,
    parameter int AW   = DW + DCOC_KMAX_DEF,
    parameter int SH_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 upd,
    input  logic signed [DW-1:0] y,
    input  logic [SH_W-1:0]      lshift,
    output logic signed [AW-1:0] acc
);
    localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW:0]   inc;
    logic signed [AW:0]   base;
    logic signed [AW:0]   sum;
    logic signed [AW-1:0] nxt;
    sat_kind_e            sat;

    always_comb begin
        inc  = {{(AW+1-DW){y[DW-1]}}, y} <<< lshift;
        base = clr ? '0 : {acc[AW-1], acc};
        sum  = base + inc;
        if (sum[AW] != sum[AW-1]) begin
            sat = sum[AW] ? SAT_LOW : SAT_HIGH;
            nxt = sum[AW] ? AMIN : AMAX;
        end else begin
            sat = SAT_NONE;
            nxt = sum[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc <= '0;
        else if (upd) acc <= nxt;
        else if (clr) acc <= '0;
    end
endmodule

// File: rtl/dcoc_loop.sv
module dcoc_loop
    import dcoc_pkg::*;
#(
    parameter int DW    = DCOC_DW_DEF,
    parameter int KMIN  = DCOC_KMIN_DEF,
    parameter int KMAX  = DCOC_KMAX_DEF,
    parameter int FRAC  = KMAX,
    parameter int AW    = DW + FRAC,
    parameter int SEL_W = $clog2(KMAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [SEL_W-1:0]     k_sel,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic signed [AW-1:0] acc_out
);
    localparam int SH_W = $clog2(KMAX - KMIN + 1) + 1;

    logic [SH_W-1:0]      lshift;
    logic signed [DW-1:0] y;
    sat_kind_e            y_sat;

    dcoc_gain_sel #(.KMIN(KMIN), .KMAX(KMAX), .SEL_W(SEL_W), .SH_W(SH_W)) u_gain (
        .k_sel (k_sel),
        .lshift(lshift)
    );

    dcoc_correct #(.DW(DW), .FRAC(FRAC), .AW(AW)) u_corr (
        .acc     (acc_out),
        .zero_est(clr),
        .x       (in_data),
        .y       (y),
        .sat     (y_sat)
    );

    dcoc_accum #(.DW(DW), .AW(AW), .SH_W(SH_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .upd   (in_valid),
        .y     (y),
        .lshift(lshift),
        .acc   (acc_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && (y_sat inside {SAT_NONE, SAT_HIGH, SAT_LOW}))
                out_data <= y;
        end
    end
endmodule

// File: rtl/dcoc_loop_chk.sv
module dcoc_loop_chk #(
    parameter int DW = 16,
    parameter int AW = 28
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_data,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_data,
    input logic signed [AW-1:0] acc_out
);
    // R1: valid pipeline of one stage
    a_r1_valid_dly: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_dly: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: integrator holds without a sample or clear
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> $stable(acc_out));
    // R3: no wrap on a positive minus negative difference
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && !in_data[DW-1] && acc_out[AW-1]) |=> !out_data[DW-1]);
    // R4: clear alone empties the integrator
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> (acc_out == '0));
    // R4: sample coinciding with clear passes through
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && in_valid) |=> (out_data == $past(in_data)));
    // R8: output holds between samples
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

bind dcoc_loop dcoc_loop_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data),
    .acc_out  (acc_out)
);

// File: tb/dcoc_loop_test.sv
module dcoc_loop_test;
    localparam int DW = 16;
    localparam int FRAC = 12;
    localparam int AW = DW + FRAC;
    localparam int SEL_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic [SEL_W-1:0] k_sel = 4'd6;
    logic out_valid;
    logic signed [DW-1:0] out_data;
    logic signed [AW-1:0] acc_out;

    dcoc_loop uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .k_sel(k_sel), .out_valid(out_valid),
        .out_data(out_data), .acc_out(acc_out)
    );

    always #2 clk = ~clk;

    typedef struct {
        int     y;
        longint a;
        bit     win;
        string  req;
    } item_t;

    item_t  sb[$];
    int     checks = 0;
    int     fails = 0;
    longint m_acc = 0;
    longint win_sum = 0;
    int     last_out = 0;
    bit     done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_sample(input int x, input int k, input bit c, input bit win, input string req);
        int     kc;
        longint base, est, y, a;
        item_t  it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        k_sel    = SEL_W'(k);
        clr      = c;
        kc   = (k < 4) ? 4 : ((k > 12) ? 12 : k);
        base = c ? 0 : m_acc;
        est  = base >>> FRAC;
        y    = x - est;
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        a = base + (y <<< (FRAC - kc));
        if (a > (64'sd1 <<< (AW-1)) - 1) a = (64'sd1 <<< (AW-1)) - 1;
        if (a < -(64'sd1 <<< (AW-1))) a = -(64'sd1 <<< (AW-1));
        m_acc  = a;
        it.y   = int'(y);
        it.a   = a;
        it.win = win;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            clr      = 1'b0;
        end
    endtask

    function automatic int sine_at(input int n);
        return $rtoi(2000.0 * $sin(2.0 * 3.14159265358979 * real'(n % 64) / 64.0));
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected output", int'(out_data), 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(int'(out_data) == it.y, {it.req, " out_data"}, int'(out_data), it.y);
                    check(longint'(acc_out) == it.a, {"R2 acc_out after ", it.req}, longint'(acc_out), it.a);
                    if (it.win) win_sum += int'(out_data);
                end
                last_out = int'(out_data);
            end else begin
                check(int'(out_data) == last_out, "R8 hold", int'(out_data), last_out);
            end
        end
    end

    task automatic dc_run(input int offs, input int k, input int settle, input int window, input string req);
        win_sum = 0;
        for (int n = 0; n < settle + window; n++)
            push_sample(offs + sine_at(n), k, 1'b0, n >= settle, req);
        idle(3);
        check((win_sum < window) && (win_sum > -window), {"R6 mean ", req}, win_sum, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        check(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
        check(out_data == '0, "R7 out_data", out_data, 0);
        check(acc_out == '0, "R7 acc_out", acc_out, 0);
        rst_n = 1'b1;
        idle(2);

        // R1/R2/R6: offset + sine, k=6, 12/beta settle
        dc_run(1000, 6, 768, 256, "R1 k6");

        // R8 / R2: gaps between samples
        for (int i = 0; i < 20; i++) begin
            push_sample(500 - 50 * i, 6, 1'b0, 1'b0, "R2 gapped");
            idle(1 + (i % 3));
        end

        // R5: gain change without clear, plus clamping of 0 and 15
        for (int i = 0; i < 30; i++) push_sample(3000, 10, 1'b0, 1'b0, "R5 k10");
        for (int i = 0; i < 30; i++) push_sample(3000, 0, 1'b0, 1'b0, "R5 k0 as 4");
        for (int i = 0; i < 30; i++) push_sample(-3000, 15, 1'b0, 1'b0, "R5 k15 as 12");
        idle(2);

        // R4: clear alone
        @(negedge clk);
        in_valid = 1'b0;
        clr = 1'b1;
        m_acc = 0;
        @(negedge clk);
        clr = 1'b0;
        check(acc_out == '0, "R4 clear alone", acc_out, 0);
        idle(1);
        // R4: clear with sample
        for (int i = 0; i < 10; i++) push_sample(1234, 4, 1'b0, 1'b0, "R4 prefill");
        push_sample(-777, 4, 1'b1, 1'b0, "R4 clear with sample");
        push_sample(-777, 4, 1'b0, 1'b0, "R4 after clear");
        idle(2);

        // R3: saturate output
        for (int i = 0; i < 300; i++) push_sample(-32768, 4, 1'b0, 1'b0, "R3 low fill");
        for (int i = 0; i < 5; i++) push_sample(32767, 4, 1'b0, 1'b0, "R3 positive sat");
        for (int i = 0; i < 300; i++) push_sample(32767, 4, 1'b0, 1'b0, "R3 high fill");
        for (int i = 0; i < 5; i++) push_sample(-32768, 4, 1'b0, 1'b0, "R3 negative sat");
        idle(2);

        // R6: second gain and negative offset
        @(negedge clk);
        clr = 1'b1;
        m_acc = 0;
        idle(1);
        dc_run(-3000, 8, 3072, 256, "R1 k8");

        check(sb.size() == 0, "R1 queue drained", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule